// File: doc/BRIEF.md
# PHY Configuration Handshake Master

This block reaches a 16-bit indirect PHY configuration space using only two words. It drives a 32-bit control word and reads back a 32-bit status word. A caller issues a single read or write command. The block turns the command into a chain of four-phase strobe/acknowledge handshakes, applies a bounded poll to every acknowledge edge, and ends the command with a one-cycle completion pulse. That pulse can carry an error flag. Read data is presented at the same time.

Every handshake raises one strobe and polls until the acknowledge is high. It then drops the strobe and polls until the acknowledge is low. Polls happen once every `POLL_GAP` clock cycles, and no wait polls more than `POLL_MAX` times.

The phases run in a fixed order for each kind of access:

- **Write:** capture-address, then capture-data, then write-strobe.
- **Read:** capture-address, then read-strobe. The read data is sampled while the read strobe and the acknowledge are both high.

One write is handled differently: a write of nonzero data to the clock/reset register. For that write, the final strobe is raised together with the data and the command completes at once. The block does not wait for an acknowledge, because after that write the PHY is resetting.

The controller has these states:

| State | Action |
|---|---|
| `ST_IDLE` | Accepts a command. |
| `ST_LOAD` | Raises the current strobe over a field that is already stable. |
| `ST_WAIT_HI` | Polls for the acknowledge to go high. |
| `ST_WAIT_LO` | Polls for the acknowledge to go low, then picks the next phase. |
| `ST_ABORT` | Drops every strobe after a timeout. |

These are its transitions:

- `ST_IDLE`→`ST_LOAD` on an accepted command.
- `ST_LOAD`→`ST_WAIT_HI` always.
- `ST_WAIT_HI`→`ST_WAIT_LO` when the acknowledge is seen high.
- `ST_WAIT_LO` on the acknowledge seen low:
  - →`ST_LOAD` when a write moves on to its data phase.
  - →`ST_WAIT_HI` when the read or write strobe is raised directly.
  - →`ST_IDLE` when the command is finished, including the reset-register shortcut.
- `ST_WAIT_HI`/`ST_WAIT_LO`→`ST_ABORT` when the last poll misses.
- `ST_ABORT`→`ST_IDLE` always.

Top module: `phy_cr_master`

## Requirements
- R1: Control word layout: bits 15:0 hold the address or data field. Bit 16 is capture-address, bit 17 is capture-data, bit 18 is write and bit 19 is read. Bits 31:20 are zero. In the status word, bit 18 is the acknowledge and bits 15:0 are the read data.
- R2: Each handshake raises exactly one strobe and waits for acknowledge = 1. It then lowers that strobe and waits for acknowledge = 0. At most one strobe is high at a time, and the field never changes in the cycle a strobe rises.
- R3: Every command first places its address in the field, with all strobes low, and then performs the capture-address handshake.
- R4: A write performs three handshakes in order: capture-address with the field equal to the address, capture-data with the field equal to the write data, then write. It completes with all strobes low and the error flag low.
- R5: A read performs capture-address and then read. `rsp_rdata` equals status bits 15:0 as sampled while the read strobe and the acknowledge are both high.
- R6: A write to address 0x7F3F with nonzero data follows the capture-data handshake with a control word of the data OR bit 18. It completes in that same cycle, without waiting for any acknowledge, and the write strobe is left high.
- R7: A write of zero data to address 0x7F3F runs the full write handshake of R4.
- R8: The acknowledge is sampled once every `POLL_GAP` cycles, at most `POLL_MAX` times per wait. An acknowledge that arrives inside that window lets the command succeed.
- R9: A wait that exhausts its polls aborts the command. It completes with the error flag high and every strobe low.
- R10: A command is accepted only while `cmd_ready` is high, which is only in the idle state. A `cmd_valid` while busy has no effect.
- R11: `rsp_done` is a one-cycle pulse at the end of every command. `rsp_err` is high only together with `rsp_done`.
- R12: After reset, the control word is zero, `cmd_ready` is high, and `rsp_done` and `rsp_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | PHY register address |
| cmd_wdata | input | 16 | Write data |
| cmd_ready | output | 1 | Idle; a command is taken this cycle |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Timeout error, paired with `rsp_done` |
| rsp_rdata | output | 16 | Data returned by the last read |
| ctl_word | output | 32 | Control word driven towards the PHY |
| stat_word | input | 32 | Status word returned by the PHY |

## Verification
A wrong phase or a wrong state appears on `ctl_word` within one cycle. A responder that logs every strobe rise together with the field value exposes it as a missing, extra or reordered handshake, or as a wrong field. A broken poll counter shows up in the completion time of a wait with a stuck acknowledge: the completion comes too early, too late, or with the wrong error flag. A mistake in the reset-register shortcut leaves the command waiting on an acknowledge that never comes, or loses the write strobe on the control word at `rsp_done`.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;

    localparam int FIELD_W    = 16;
    localparam int STROBE_LSB = 16;  // capture-addr, capture-data, write, read
    localparam int ACK_BIT    = 18;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WAIT_HI,
        ST_WAIT_LO,
        ST_ABORT
    } st_e;

    // Encoding equals the strobe offset above STROBE_LSB
    typedef enum logic [1:0] {
        PH_ADDR  = 2'd0,
        PH_DATA  = 2'd1,
        PH_WRITE = 2'd2,
        PH_READ  = 2'd3
    } ph_e;

endpackage

// File: rtl/phy_poll_pacer.sv
module phy_poll_pacer #(
    parameter int POLL_MAX = 5000,
    parameter int POLL_GAP = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic step,
    output logic sample_now,
    output logic last_poll
);
    localparam int PW = $clog2(POLL_MAX + 1);
    localparam int GW = $clog2(POLL_GAP + 1);

    logic [PW-1:0] poll_cnt;
    logic [GW-1:0] gap_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_cnt <= '0;
            gap_cnt  <= '0;
        end else if (restart) begin
            poll_cnt <= '0;
            gap_cnt  <= '0;
        end else if (step && sample_now) begin
            poll_cnt <= poll_cnt + 1'b1;
            gap_cnt  <= GW'(POLL_GAP - 1);
        end else if (gap_cnt != '0) begin
            gap_cnt <= gap_cnt - 1'b1;
        end
    end

    assign sample_now = (gap_cnt == '0);
    assign last_poll  = (poll_cnt == PW'(POLL_MAX - 1));

    // R8
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt < PW'(POLL_MAX));
    // R8
    gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap_cnt < GW'(POLL_GAP));

endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master
    import phy_cr_pkg::*;
#(
    parameter int          POLL_MAX  = 5000,
    parameter int          POLL_GAP  = 100,
    parameter logic [15:0] RESET_REG = 16'h7F3F
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic        cmd_write,
    input  logic [15:0] cmd_addr,
    input  logic [15:0] cmd_wdata,
    output logic        cmd_ready,
    output logic        rsp_done,
    output logic        rsp_err,
    output logic [15:0] rsp_rdata,
    output logic [31:0] ctl_word,
    input  logic [31:0] stat_word
);
    st_e                 state, state_d;
    ph_e                 phase;
    logic                op_write;
    logic [15:0]         op_addr, op_data;
    logic [FIELD_W-1:0]  field_q;
    logic [3:0]          strobe_q;
    logic                done_q, err_q;
    logic [15:0]         rdata_q;

    logic ack, in_wait, want, match, hit, miss_last, step, special;
    logic start_wait, sample_now, last_poll;
    logic unused_stat;

    assign ack         = stat_word[ACK_BIT];
    assign unused_stat = ^{stat_word[31:ACK_BIT+1], stat_word[ACK_BIT-1:FIELD_W]};
    assign in_wait     = (state == ST_WAIT_HI) || (state == ST_WAIT_LO);
    assign want        = (state == ST_WAIT_HI);
    assign match       = (ack == want);
    assign hit         = in_wait && sample_now && match;
    assign miss_last   = in_wait && sample_now && !match && last_poll;
    assign step        = in_wait && !match && !last_poll;
    assign special     = op_write && (op_addr == RESET_REG) && (op_data != '0);
    assign start_wait  = ((state_d == ST_WAIT_HI) || (state_d == ST_WAIT_LO))
                         && (state_d != state);

    phy_poll_pacer #(.POLL_MAX(POLL_MAX), .POLL_GAP(POLL_GAP)) u_pacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (start_wait),
        .step       (step),
        .sample_now (sample_now),
        .last_poll  (last_poll)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:    if (cmd_valid) state_d = ST_LOAD;
            ST_LOAD:    state_d = ST_WAIT_HI;
            ST_WAIT_HI: begin
                if (hit)            state_d = ST_WAIT_LO;
                else if (miss_last) state_d = ST_ABORT;
            end
            ST_WAIT_LO: begin
                if (hit) begin
                    unique case (phase)
                        PH_ADDR: state_d = op_write ? ST_LOAD : ST_WAIT_HI;
                        PH_DATA: state_d = special ? ST_IDLE : ST_WAIT_HI;
                        default: state_d = ST_IDLE;
                    endcase
                end else if (miss_last) begin
                    state_d = ST_ABORT;
                end
            end
            ST_ABORT:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= PH_ADDR;
            op_write <= 1'b0;
            op_addr  <= '0;
            op_data  <= '0;
            field_q  <= '0;
            strobe_q <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            rdata_q  <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state)
                ST_IDLE: if (cmd_valid) begin
                    op_write <= cmd_write;
                    op_addr  <= cmd_addr;
                    op_data  <= cmd_wdata;
                    phase    <= PH_ADDR;
                    field_q  <= cmd_addr;
                    strobe_q <= '0;
                end
                ST_LOAD: strobe_q[phase] <= 1'b1;
                ST_WAIT_HI: if (hit) begin
                    strobe_q <= '0;
                    if (phase == PH_READ) rdata_q <= stat_word[FIELD_W-1:0];
                end
                ST_WAIT_LO: if (hit) begin
                    unique case (phase)
                        PH_ADDR: begin
                            if (op_write) begin
                                phase   <= PH_DATA;
                                field_q <= op_data;
                            end else begin
                                phase             <= PH_READ;
                                strobe_q[PH_READ] <= 1'b1;
                            end
                        end
                        PH_DATA: begin
                            strobe_q[PH_WRITE] <= 1'b1;
                            if (special) done_q <= 1'b1;
                            else         phase  <= PH_WRITE;
                        end
                        default: done_q <= 1'b1;
                    endcase
                end
                ST_ABORT: begin
                    strobe_q <= '0;
                    done_q   <= 1'b1;
                    err_q    <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign cmd_ready = (state == ST_IDLE);
    assign rsp_done  = done_q;
    assign rsp_err   = err_q;
    assign rsp_rdata = rdata_q;
    assign ctl_word  = {{(32-STROBE_LSB-4){1'b0}}, strobe_q, field_q};

    // R2
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctl_word[STROBE_LSB+3:STROBE_LSB]));
    // R2
    field_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|ctl_word[STROBE_LSB+3:STROBE_LSB]) |-> $stable(ctl_word[15:0]));
    // R9
    abort_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (ctl_word[STROBE_LSB+3:STROBE_LSB] == 4'b0));
    // R11
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ctl_word[STROBE_LSB+3:STROBE_LSB] && !rsp_done) |-> !cmd_ready || ctl_word[STROBE_LSB+2]);

endmodule

// File: tb/phy_cr_master_test.sv
`timescale 1ns/1ps
module phy_cr_master_test;
    localparam int PMAX = 8;
    localparam int PGAP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [15:0] cmd_addr = '0, cmd_wdata = '0;
    logic        cmd_ready, rsp_done, rsp_err;
    logic [15:0] rsp_rdata;
    logic [31:0] ctl_word, stat_word;

    always #2.5 clk = ~clk;

    phy_cr_master #(.POLL_MAX(PMAX), .POLL_GAP(PGAP)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .ctl_word(ctl_word), .stat_word(stat_word)
    );

    // Behavioural PHY responder
    int          lat = 0;
    int          mode = 0;   // 0 follow, 1 ack stuck low, 2 ack stuck high
    int          cnt = 0;
    logic        ack = 1'b0;
    logic [3:0]  prev_stb = '0;
    logic [15:0] r_addr = '0, r_data = '0, mem_addr = '0, mem_data = '0;
    logic        mem_valid = 1'b0;
    int          log_code [0:7];
    logic [15:0] log_field [0:7];
    int          log_n = 0;
    logic [15:0] rd_val;

    assign rd_val    = (mem_valid && mem_addr == r_addr) ? mem_data : (r_addr ^ 16'h5A5A);
    assign stat_word = ({31'b0, ack} << 18) | {16'b0, (ctl_word[19] ? rd_val : 16'h0)};

    always @(posedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (ctl_word[16+i] && !prev_stb[i]) begin
                if (log_n < 8) begin
                    log_code[log_n]  = i;
                    log_field[log_n] = ctl_word[15:0];
                end
                log_n = log_n + 1;
                if (i == 0) r_addr = ctl_word[15:0];
                if (i == 1) r_data = ctl_word[15:0];
                if (i == 2) begin mem_addr = r_addr; mem_data = r_data; mem_valid = 1'b1; end
            end
        end
        prev_stb = ctl_word[19:16];
        if (mode == 1) ack <= 1'b0;
        else if (mode == 2) ack <= 1'b1;
        else if (ack != (|ctl_word[19:16])) begin
            if (cnt >= lat) begin ack <= |ctl_word[19:16]; cnt = 0; end
            else cnt = cnt + 1;
        end else cnt = 0;
    end

    int checks = 0, fails = 0;
    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    int          cyc;
    logic        got_err;
    logic [15:0] got_rd;
    logic [31:0] got_ctl, got_stat;

    task automatic run_cmd(input bit w, input logic [15:0] a, input logic [15:0] d);
        log_n = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 1;
        while (!rsp_done && cyc < 2000) begin @(negedge clk); cyc++; end
        got_err = rsp_err; got_rd = rsp_rdata; got_ctl = ctl_word; got_stat = stat_word;
        check(rsp_done, "R11 done seen", {31'b0, rsp_done}, 1);
        @(negedge clk);
        check(!rsp_done && !rsp_err, "R11 single-cycle done/err", {30'b0, rsp_done, rsp_err}, 0);
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        summary;
        $finish;
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        // R12 reset state
        check(ctl_word == 0, "R12 ctl zero", ctl_word, 0);
        check(cmd_ready && !rsp_done && !rsp_err, "R12 ready/done/err",
              {29'b0, cmd_ready, rsp_done, rsp_err}, 32'h4);

        // Sweep of responder latency and addresses
        for (int l = 0; l < 6; l++) begin
            for (int k = 0; k < 3; k++) begin
                logic [15:0] a, d;
                a = 16'(l * 37 + k * 1000 + 1);
                d = a * 16'd3 ^ 16'h1234;
                lat = l;
                run_cmd(1'b1, a, d);
                check(!got_err, "R4 write no error", {31'b0, got_err}, 0);
                check(got_ctl[31:16] == 0, "R4 R1 strobes low at end", got_ctl, {16'b0, got_ctl[15:0]});
                check(log_n == 3, "R4 three handshakes", log_n, 3);
                check(log_code[0] == 0 && log_field[0] == a, "R3 address phase first", {16'(log_code[0]), log_field[0]}, {16'd0, a});
                check(log_code[1] == 1 && log_field[1] == d, "R4 data phase", {16'(log_code[1]), log_field[1]}, {16'd1, d});
                check(log_code[2] == 2, "R4 write strobe bit 18", log_code[2], 2);
                run_cmd(1'b0, a, 16'h0);
                check(!got_err && got_rd == d, "R5 read back", {15'b0, got_err, got_rd}, {16'b0, d});
                check(log_n == 2 && log_code[1] == 3, "R5 read strobe bit 19", {16'(log_n), 16'(log_code[1])}, {16'd2, 16'd3});
                run_cmd(1'b0, a + 16'd1, 16'h0);
                check(got_rd == ((a + 16'd1) ^ 16'h5A5A), "R5 read other", got_rd, (a + 16'd1) ^ 16'h5A5A);
            end
        end

        // R8 late but in-window acknowledge
        lat = 15;
        run_cmd(1'b1, 16'h0222, 16'hC0DE);
        check(!got_err && log_n == 3, "R8 late ack succeeds", {15'b0, got_err, 16'(log_n)}, 3);

        // R6 reset-register shortcut
        lat = 4;
        run_cmd(1'b1, 16'h7F3F, 16'h0001);
        check(!got_err && got_ctl == 32'h0004_0001, "R6 final word", got_ctl, 32'h0004_0001);
        check(got_stat[18] == 1'b0, "R6 no ack wait", {31'b0, got_stat[18]}, 0);
        check(log_n == 3 && log_code[2] == 2, "R6 write strobe raised", log_n, 3);
        settle(20);
        check(ctl_word[18] == 1'b1, "R6 strobe left high", ctl_word, 32'h0004_0001);
        run_cmd(1'b0, 16'h0010, 16'h0);
        check(!got_err && got_rd == (16'h0010 ^ 16'h5A5A), "R3 recovery read", got_rd, 16'h0010 ^ 16'h5A5A);

        // R7 zero data to reset register
        run_cmd(1'b1, 16'h7F3F, 16'h0000);
        check(!got_err && got_ctl[18] == 1'b0 && log_n == 3, "R7 full handshake",
              {got_ctl[18], 15'b0, 16'(log_n)}, 32'h0000_0003);

        // R9 / R8 acknowledge never rises
        mode = 1;
        run_cmd(1'b1, 16'h0100, 16'h0200);
        check(got_err, "R9 timeout error", {31'b0, got_err}, 1);
        check(got_ctl[19:16] == 0, "R9 strobes low", got_ctl, {12'b0, 4'b0, got_ctl[15:0]});
        check(cyc >= 2 + (PMAX - 1) * PGAP && cyc <= 6 + (PMAX - 1) * PGAP, "R8 poll window", cyc, 3 + (PMAX - 1) * PGAP);

        // R9 acknowledge never falls
        mode = 2;
        run_cmd(1'b0, 16'h0300, 16'h0);
        check(got_err && got_ctl[19:16] == 0, "R9 stuck-high timeout", got_ctl, 32'h0);
        mode = 0; lat = 0;
        settle(5);

        // R8 acknowledge too late
        lat = 25;
        run_cmd(1'b0, 16'h0400, 16'h0);
        check(got_err, "R8 late ack times out", {31'b0, got_err}, 1);
        lat = 0;
        settle(40);

        // R10 command while busy ignored
        log_n = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 16'h0ABC; cmd_wdata = 16'h1357;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        settle(3);
        check(!cmd_ready, "R10 not ready while busy", {31'b0, cmd_ready}, 0);
        cmd_valid = 1'b1; cmd_addr = 16'hBEEF; cmd_wdata = 16'hFFFF;
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 0;
        while (!rsp_done && cyc < 2000) begin @(negedge clk); cyc++; end
        settle(10);
        check(log_n == 3, "R10 no second command", log_n, 3);
        check(log_field[0] == 16'h0ABC && log_field[1] == 16'h1357, "R10 fields kept",
              {log_field[0], log_field[1]}, 32'h0ABC_1357);

        summary;
        $finish;
    end
endmodule